// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general-purpose timer. It watches an external counter value and its count direction. From the selected compare mode it produces a channel reference level, `ref_o`, plus a second output, `cref_o`, that can merge this channel's reference with the reference of a partner channel. The counter, dead-time insertion, polarity, output enables and the bus interface all live outside this block.

Software-side logic drives two write strobes:
- `cfg_we_i` loads the configuration: a 3-bit mode field, an extension bit, preload enable, clear enable and trigger-fast enable.
- `cmp_we_i` writes the compare value.

The compare value either takes effect directly or waits in a shadow register until an update event. A clear input can pull the reference low at once, and the clear stays in force until the next update event. The channel state advances on each rising clock edge, using the inputs that were present before that edge. The clear gating and the combined output follow their inputs in the same cycle.

Top module: `oc_channel`

## Requirements
- R1: While reset is low and right after it, all configuration reads as zero (code 0, preload off, clear off, fast off), the active compare value is 0, and both `ref_o` and `cref_o` are 0.
- R2: The active code is `{cfg_ext_i, cfg_mode_i}`, with the extension bit as bit 3. Code 0 holds the reference. Code 1 sets it to 1 when the counter equals the active compare value. Code 2 clears it to 0 on that match. Otherwise codes 1 and 2 hold.
- R3: Code 3 inverts the reference on each match. Code 4 drives it to 0 and code 5 drives it to 1, whatever the counter does.
- R4: Code 6 gives a PWM level. Counting up (`cnt_down_i`=0), the reference is 1 when the counter is below the compare value. Counting down, it is 1 when the counter is at or below the compare value. Code 7 gives the complement of code 6.
- R5: Codes 12 and 14 drive the reference like code 6, and codes 13 and 15 drive it like code 7. With code 12, `cref_o` is the OR of `ref_o` and `partner_ref_i`. With code 13, it is their AND.
- R6: With codes 14 and 15, `cref_o` equals `ref_o` while counting up and equals `partner_ref_i` while counting down. With all codes other than 12 to 15, `cref_o` equals `ref_o`.
- R7: Code 8, counting up: a trigger drives the reference to 0, otherwise an update event drives it to 1, otherwise it holds. Code 8 counting down drives it to 0. Code 9 is the mirror: trigger gives 1, update gives 0, and counting down gives 1.
- R8: Codes 10 and 11 leave the reference unchanged.
- R9: With preload off, a compare write becomes the active compare value at the next clock edge.
- R10: With preload on, a compare write goes only to the shadow register. An update event copies the shadow, as it was before that edge, into the active compare value. Without an update, the active value stays unchanged.
- R11: With clear enable set, `ref_o` is 0 in any cycle in which `clr_i` is 1. With clear enable off, `clr_i` has no effect on `ref_o`.
- R12: Once a clear has been seen with clear enable set, `ref_o` stays 0 in later cycles until an update event without `clr_i` has been taken.
- R13: With fast enable set, a trigger makes the next reference value the one the mode gives when the counter equals the compare value, whatever the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Current counter value |
| cnt_down_i | input | 1 | 1 while the counter counts down |
| upd_i | input | 1 | Update-event strobe |
| trig_i | input | 1 | Trigger strobe |
| clr_i | input | 1 | Reference clear request |
| partner_ref_i | input | 1 | Reference of the partner channel |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Mode field (code bits 2:0) |
| cfg_ext_i | input | 1 | Extension bit (code bit 3) |
| cfg_pre_i | input | 1 | Preload enable |
| cfg_clren_i | input | 1 | Clear enable |
| cfg_fast_i | input | 1 | Trigger-fast enable |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_val_i | input | CNT_W | Compare value to write |
| ref_o | output | 1 | Channel reference after clear gating |
| cref_o | output | 1 | Combined reference |

## Verification
The registered reference, the configuration and the active compare value change at the first rising edge after their inputs are presented. The clear gating of `ref_o` and the whole of `cref_o` depend on the present inputs within the same cycle. The bench therefore drives its inputs just after a rising edge and compares both outputs at the following falling edge against a behavioural model. It advances that model exactly once per rising edge, using the inputs that were held across it. Every code is swept in both directions with compare values of 0, 4 and the maximum count. Directed sequences then cover preload, clearing and fast triggering.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [3:0] {
    OC_FROZEN    = 4'd0,
    OC_SET_HIT   = 4'd1,
    OC_CLR_HIT   = 4'd2,
    OC_TOGGLE    = 4'd3,
    OC_FORCE_LO  = 4'd4,
    OC_FORCE_HI  = 4'd5,
    OC_PWM_A     = 4'd6,
    OC_PWM_B     = 4'd7,
    OC_PULSE_A   = 4'd8,
    OC_PULSE_B   = 4'd9,
    OC_RSVD_A    = 4'd10,
    OC_RSVD_B    = 4'd11,
    OC_COMB_OR   = 4'd12,
    OC_COMB_AND  = 4'd13,
    OC_ASYM_A    = 4'd14,
    OC_ASYM_B    = 4'd15
  } oc_code_e;

  // PWM level: up-count active below compare, down-count active at or below
  function automatic logic pwm_level(input logic [31:0] cnt, input logic [31:0] cmp,
                                     input logic down);
    if (down) return (cnt <= cmp);
    return (cnt < cmp);
  endfunction

  // Next registered reference for a code
  function automatic logic next_ref(input oc_code_e code, input logic cur, input logic hit,
                                    input logic lvl, input logic down, input logic trig,
                                    input logic upd);
    case (code)
      OC_SET_HIT:  return hit ? 1'b1 : cur;
      OC_CLR_HIT:  return hit ? 1'b0 : cur;
      OC_TOGGLE:   return hit ? ~cur : cur;
      OC_FORCE_LO: return 1'b0;
      OC_FORCE_HI: return 1'b1;
      OC_PWM_A, OC_COMB_OR, OC_ASYM_A:  return lvl;
      OC_PWM_B, OC_COMB_AND, OC_ASYM_B: return ~lvl;
      OC_PULSE_A:  return down ? 1'b0 : (trig ? 1'b0 : (upd ? 1'b1 : cur));
      OC_PULSE_B:  return down ? 1'b1 : (trig ? 1'b1 : (upd ? 1'b0 : cur));
      default:     return cur;
    endcase
  endfunction

  // Combined reference selection
  function automatic logic combine(input oc_code_e code, input logic own,
                                   input logic partner, input logic down);
    case (code)
      OC_COMB_OR:           return own | partner;
      OC_COMB_AND:          return own & partner;
      OC_ASYM_A, OC_ASYM_B: return down ? partner : own;
      default:              return own;
    endcase
  endfunction

endpackage

// File: rtl/oc_cfg_regs.sv
module oc_cfg_regs
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic             cfg_ext_i,
  input  logic             cfg_pre_i,
  input  logic             cfg_clren_i,
  input  logic             cfg_fast_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             upd_i,
  output oc_code_e         code_o,
  output logic             pre_o,
  output logic             clren_o,
  output logic             fast_o,
  output logic [CNT_W-1:0] cmp_act_o
);

  oc_code_e         code_q;
  logic             pre_q, clren_q, fast_q;
  logic [CNT_W-1:0] shadow_q, act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q   <= OC_FROZEN;
      pre_q    <= 1'b0;
      clren_q  <= 1'b0;
      fast_q   <= 1'b0;
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (cfg_we_i) begin
        code_q  <= oc_code_e'({cfg_ext_i, cfg_mode_i});
        pre_q   <= cfg_pre_i;
        clren_q <= cfg_clren_i;
        fast_q  <= cfg_fast_i;
      end
      if (cmp_we_i) shadow_q <= cmp_val_i;
      if (cmp_we_i && !pre_q) act_q <= cmp_val_i;
      else if (pre_q && upd_i) act_q <= shadow_q;
    end
  end

  assign code_o    = code_q;
  assign pre_o     = pre_q;
  assign clren_o   = clren_q;
  assign fast_o    = fast_q;
  assign cmp_act_o = act_q;

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  oc_code_e         code_i,
  input  logic             fast_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             trig_i,
  input  logic             upd_i,
  output logic             ref_q_o
);

  logic [CNT_W-1:0] eff_cnt;
  logic             hit, lvl, ref_d, ref_q;

  // fast trigger evaluates the mode as if the counter sat on the compare value
  assign eff_cnt = (fast_i && trig_i) ? cmp_i : cnt_i;
  assign hit     = (eff_cnt == cmp_i);
  assign lvl     = pwm_level(32'(eff_cnt), 32'(cmp_i), down_i);
  assign ref_d   = next_ref(code_i, ref_q, hit, lvl, down_i, trig_i, upd_i);

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_d;
  end

  assign ref_q_o = ref_q;

endmodule

// File: rtl/oc_clear.sv
module oc_clear (
  input  logic clk,
  input  logic rst_n,
  input  logic clren_i,
  input  logic clr_i,
  input  logic upd_i,
  input  logic ref_raw_i,
  output logic ref_o,
  output logic hold_o
);

  logic hold_q, blank;

  always_ff @(posedge clk) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (clren_i) hold_q <= clr_i | (hold_q & ~upd_i);
    else              hold_q <= 1'b0;
  end

  assign blank  = clren_i & (clr_i | hold_q);
  assign ref_o  = ref_raw_i & ~blank;
  assign hold_o = hold_q;

endmodule

// File: rtl/oc_combine.sv
module oc_combine
  import oc_pkg::*;
(
  input  oc_code_e code_i,
  input  logic     ref_i,
  input  logic     partner_i,
  input  logic     down_i,
  output logic     cref_o
);

  assign cref_o = combine(code_i, ref_i, partner_i, down_i);

endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             upd_i,
  input  logic             trig_i,
  input  logic             clr_i,
  input  logic             partner_ref_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic             cfg_ext_i,
  input  logic             cfg_pre_i,
  input  logic             cfg_clren_i,
  input  logic             cfg_fast_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  output logic             ref_o,
  output logic             cref_o
);

  oc_code_e         code;
  logic             pre, clren, fast;
  logic [CNT_W-1:0] cmp_act;
  logic             ref_raw, ref_gated, hold;

  oc_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i), .cfg_ext_i(cfg_ext_i),
    .cfg_pre_i(cfg_pre_i), .cfg_clren_i(cfg_clren_i), .cfg_fast_i(cfg_fast_i),
    .cmp_we_i(cmp_we_i), .cmp_val_i(cmp_val_i), .upd_i(upd_i),
    .code_o(code), .pre_o(pre), .clren_o(clren), .fast_o(fast), .cmp_act_o(cmp_act)
  );

  oc_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .code_i(code), .fast_i(fast),
    .cnt_i(cnt_i), .down_i(cnt_down_i), .cmp_i(cmp_act),
    .trig_i(trig_i), .upd_i(upd_i), .ref_q_o(ref_raw)
  );

  oc_clear u_clr (
    .clk(clk), .rst_n(rst_n), .clren_i(clren), .clr_i(clr_i), .upd_i(upd_i),
    .ref_raw_i(ref_raw), .ref_o(ref_gated), .hold_o(hold)
  );

  oc_combine u_comb (
    .code_i(code), .ref_i(ref_gated), .partner_i(partner_ref_i),
    .down_i(cnt_down_i), .cref_o(cref_o)
  );

  assign ref_o = ref_gated;

endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       code_i,
  input logic             pre_i,
  input logic             clren_i,
  input logic             clr_i,
  input logic             upd_i,
  input logic             cmp_we_i,
  input logic [CNT_W-1:0] cmp_val_i,
  input logic [CNT_W-1:0] cmp_act_i,
  input logic             ref_raw_i,
  input logic             ref_i,
  input logic             hold_i
);

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code_i) == 4'd0) |-> (ref_raw_i == $past(ref_raw_i))); // R2

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code_i) == 4'd4) |-> !ref_raw_i); // R3

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code_i) == 4'd5) |-> ref_raw_i); // R3

  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we_i && !pre_i) |=> (cmp_act_i == $past(cmp_val_i))); // R9

  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && !upd_i) |=> $stable(cmp_act_i)); // R10

  AST_CLEAR_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (clren_i && clr_i) |-> !ref_i); // R11

  AST_CLEAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (clren_i && $past(clren_i && clr_i)) |-> (hold_i && !ref_i)); // R12

endmodule

bind oc_channel oc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .code_i(code), .pre_i(pre), .clren_i(clren),
  .clr_i(clr_i), .upd_i(upd_i), .cmp_we_i(cmp_we_i), .cmp_val_i(cmp_val_i),
  .cmp_act_i(cmp_act), .ref_raw_i(ref_raw), .ref_i(ref_o), .hold_i(hold)
);

// File: tb/oc_channel_bench.sv
module oc_channel_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [W-1:0] cnt = '0;
  logic down = 0, upd = 0, trig = 0, clr = 0, partner = 0;
  logic cfg_we = 0, cfg_ext = 0, cfg_pre = 0, cfg_clren = 0, cfg_fast = 0;
  logic [2:0] cfg_mode = '0;
  logic cmp_we = 0;
  logic [W-1:0] cmp_val = '0;
  logic ref_o, cref_o;

  oc_channel #(.CNT_W(W)) u_oc_channel (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_down_i(down), .upd_i(upd),
    .trig_i(trig), .clr_i(clr), .partner_ref_i(partner), .cfg_we_i(cfg_we),
    .cfg_mode_i(cfg_mode), .cfg_ext_i(cfg_ext), .cfg_pre_i(cfg_pre),
    .cfg_clren_i(cfg_clren), .cfg_fast_i(cfg_fast), .cmp_we_i(cmp_we),
    .cmp_val_i(cmp_val), .ref_o(ref_o), .cref_o(cref_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string req = "R1";

  // behavioural model state
  int m_code = 0, m_shadow = 0, m_act = 0;
  bit m_pre = 0, m_clren = 0, m_fast = 0, m_ref = 0, m_hold = 0;

  function automatic bit m_next(int code, bit r, int c, int k, bit dn, bit tg, bit up, bit fst);
    int e;
    bit hit, lvl;
    e = (fst && tg) ? k : c;
    hit = (e == k);
    lvl = dn ? (e <= k) : (e < k);
    case (code)
      1: return hit ? 1'b1 : r;
      2: return hit ? 1'b0 : r;
      3: return hit ? !r : r;
      4: return 1'b0;
      5: return 1'b1;
      6, 12, 14: return lvl;
      7, 13, 15: return !lvl;
      8: return dn ? 1'b0 : (tg ? 1'b0 : (up ? 1'b1 : r));
      9: return dn ? 1'b1 : (tg ? 1'b1 : (up ? 1'b0 : r));
      default: return r;
    endcase
  endfunction

  function automatic bit m_cref(int code, bit ro, bit p, bit dn);
    if (code == 12) return ro | p;
    if (code == 13) return ro & p;
    if (code >= 14) return dn ? p : ro;
    return ro;
  endfunction

  function automatic string req_of(int code);
    if (code <= 2) return "R2";
    if (code <= 5) return "R3";
    if (code <= 7) return "R4";
    if (code <= 9) return "R7";
    if (code <= 11) return "R8";
    if (code <= 13) return "R5";
    return "R6";
  endfunction

  task automatic check(string r, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", r, what, act, exp);
    end
  endtask

  task automatic tick();
    bit eo, n_ref, n_hold;
    int n_act, n_shadow;
    @(negedge clk);
    eo = m_ref & !(m_clren & (clr | m_hold));
    check(req, "ref_o", ref_o, eo);
    check(req, "cref_o", cref_o, m_cref(m_code, eo, partner, down));
    n_ref = m_next(m_code, m_ref, int'(cnt), m_act, down, trig, upd, m_fast);
    n_hold = m_clren ? (clr | (m_hold & !upd)) : 1'b0;
    n_shadow = cmp_we ? int'(cmp_val) : m_shadow;
    n_act = m_act;
    if (cmp_we && !m_pre) n_act = int'(cmp_val);
    else if (m_pre && upd) n_act = m_shadow;
    @(posedge clk);
    m_ref = n_ref; m_hold = n_hold; m_shadow = n_shadow; m_act = n_act;
    if (cfg_we) begin
      m_code = {28'd0, cfg_ext, cfg_mode};
      m_pre = cfg_pre; m_clren = cfg_clren; m_fast = cfg_fast;
    end
    #1;
    cfg_we = 0; cmp_we = 0; upd = 0; trig = 0;
  endtask

  task automatic set_cfg(int code, bit pre, bit ce, bit fst);
    cfg_mode = code[2:0]; cfg_ext = code[3];
    cfg_pre = pre; cfg_clren = ce; cfg_fast = fst; cfg_we = 1;
    tick();
  endtask

  task automatic put_cmp(int v);
    cmp_val = v[W-1:0]; cmp_we = 1;
    tick();
  endtask

  task automatic sweep();
    int pts[12] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 65534, 65535};
    for (int i = 0; i < 12; i++) begin
      cnt = pts[i][W-1:0]; down = 0; trig = (i == 3); upd = (i == 0 || i == 7);
      partner = i[0];
      tick();
    end
    for (int i = 11; i >= 0; i--) begin
      cnt = pts[i][W-1:0]; down = 1; trig = (i == 3); upd = (i == 11 || i == 7);
      partner = i[1];
      tick();
    end
    down = 0;
  endtask

  initial begin
    int ks[3] = '{4, 0, 65535};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "ref_o in reset", ref_o, 1'b0);
    check("R1", "cref_o in reset", cref_o, 1'b0);
    @(posedge clk);
    #1 rst_n = 1;
    req = "R1";
    tick();
    tick();

    // every code, both directions, compare 4 / 0 / max
    for (int code = 15; code >= 0; code--) begin
      req = req_of(code);
      set_cfg(code, 0, 0, 0);
      for (int j = 0; j < 3; j++) begin
        put_cmp(ks[j]);
        sweep();
      end
    end

    // R13: fast trigger with set-on-match and PWM codes
    req = "R13";
    set_cfg(1, 0, 0, 1); put_cmp(4); set_cfg(2, 0, 0, 1); sweep();
    set_cfg(1, 0, 0, 1); sweep();
    set_cfg(6, 0, 0, 1); sweep();
    set_cfg(7, 0, 0, 1); sweep();

    // R9: direct compare load is used on the next edge
    req = "R9";
    set_cfg(6, 0, 0, 0);
    cnt = 3; put_cmp(2); tick();
    put_cmp(8); tick(); tick();

    // R10: preload holds until update
    req = "R10";
    put_cmp(2);
    set_cfg(6, 1, 0, 0);
    cnt = 5; put_cmp(9); tick(); tick(); tick();
    upd = 1; tick(); tick(); tick();

    // R11 / R12: clearing with force-high
    req = "R11";
    set_cfg(5, 0, 1, 0); tick(); tick();
    clr = 1; tick();
    clr = 0;
    req = "R12";
    tick(); tick(); tick();
    upd = 1; tick(); tick(); tick();
    req = "R11";
    set_cfg(5, 0, 0, 0);
    clr = 1; tick(); tick();
    clr = 0; tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired during %s", req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule